// File: doc/BRIEF.md
# Internal Bus Address Window Decoder

This block sits between a 32-bit internal peripheral bus and the units behind it. Each request carries an address, a size code and a read/write flag. The block compares the address against five fixed windows. Two windows lead to a byte-addressed ISA-style space: one to the I/O space and one to the memory space. A third window carries firmware traffic. The last two are small register files, one for the bus master and one for the host controller.

The block answers one clock after the request. The answer holds a one-hot target select and the offset of the address inside the matched window. The memory window and the firmware window both translate to offset zero of the same memory space. Firmware hits therefore raise a separate flag, so the engine further down can issue firmware cycles rather than plain memory cycles.

The memory window runs 64 KiB past the start of the firmware window. In that shared range the firmware window wins. Register windows take whole-word accesses only. An address that no window claims, or a register access of the wrong size, returns a decode error and selects nothing.

Top module: `lpc_opb_win_decode`

## Requirements
- R1: While reset is held, and on the first sample after it is released with no request, every output is zero.
- R2: A request presented with req_valid high appears on the outputs exactly one clock later with rsp_valid high. rsp_write and rsp_size echo req_write and req_size. When req_valid is low, the next cycle shows rsp_valid low and all other outputs zero.
- R3: Addresses 0xD001_0000 to 0xD001_FFFF select the I/O target on rsp_sel bit 2. The offset is the address minus 0xD001_0000.
- R4: Addresses 0xE001_0000 to 0xEFFF_FFFF select the memory target on rsp_sel bit 1. The offset is the address minus 0xE001_0000.
- R5: Addresses 0xF000_0000 to 0xFFFF_FFFF select the firmware target on rsp_sel bit 0. The offset is the address minus 0xF000_0000. rsp_fw_cycle is high for this target and for no other.
- R6: Addresses 0xF000_0000 to 0xF000_FFFF fall inside both the 256 MiB memory window and the firmware window. They are routed to the firmware target.
- R7: Addresses 0xC001_0000 to 0xC001_1FFF select the master register target on rsp_sel bit 3, with offset equal to the address minus 0xC001_0000. Addresses 0xC001_2000 to 0xC001_2FFF select the host controller register target on rsp_sel bit 4, with offset equal to the address minus 0xC001_2000.
- R8: Size codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. A register window access whose size code is not 2 gives rsp_decode_error high, rsp_sel zero, rsp_offset zero and rsp_fw_cycle low.
- R9: An address in no window gives rsp_decode_error high, rsp_sel zero, rsp_offset zero and rsp_fw_cycle low. This includes the byte just below a window base and the byte just past a window end.
- R10: The I/O, memory and firmware windows accept every size code.
- R11: When rsp_valid is high, rsp_sel has at most one bit set, and rsp_decode_error is high exactly when rsp_sel is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Bus address |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Decode result present |
| rsp_sel | output | 5 | One-hot target: 0 firmware, 1 memory, 2 I/O, 3 master regs, 4 host regs |
| rsp_offset | output | 32 | Address relative to the base of the selected window |
| rsp_write | output | 1 | Echoed read/write flag |
| rsp_size | output | 2 | Echoed size code |
| rsp_decode_error | output | 1 | No window matched, or register access of the wrong size |
| rsp_fw_cycle | output | 1 | Selected target is the firmware window |

## Verification
The decoder is driven with directed addresses at each window's first byte and last byte, and at the byte just outside each edge. These show whether the range compares are off by one at either end. Addresses in the memory and firmware overlap show whether the priority between those two windows is right. Register addresses with every size code show whether the word-only rule is applied to the register windows alone. Seeded random addresses, most of them aimed inside or near a window and the rest spread over the full 4 GiB space, are checked against a bench model of all five windows. They catch wrong offset muxing or flags that a single directed case would miss.

// File: rtl/lpc_win_pkg.sv
`timescale 1ns/1ps
package lpc_win_pkg;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 2;
    localparam int NTGT   = 5;

    // Target index order is also decode priority: lower index wins on overlap
    localparam int T_FW   = 0;
    localparam int T_MEM  = 1;
    localparam int T_IO   = 2;
    localparam int T_MREG = 3;
    localparam int T_HREG = 4;

    localparam logic [SIZE_W-1:0] SZ_WORD = 2'd2;

    localparam logic [ADDR_W-1:0] DEF_FW_BASE   = 32'hF000_0000;
    localparam logic [ADDR_W:0]   DEF_FW_SPAN   = 33'h0_1000_0000;
    localparam logic [ADDR_W-1:0] DEF_MEM_BASE  = 32'hE001_0000;
    localparam logic [ADDR_W:0]   DEF_MEM_SPAN  = 33'h0_1000_0000;
    localparam logic [ADDR_W-1:0] DEF_IO_BASE   = 32'hD001_0000;
    localparam logic [ADDR_W:0]   DEF_IO_SPAN   = 33'h0_0001_0000;
    localparam logic [ADDR_W-1:0] DEF_MREG_BASE = 32'hC001_0000;
    localparam logic [ADDR_W:0]   DEF_MREG_SPAN = 33'h0_0000_2000;
    localparam logic [ADDR_W-1:0] DEF_HREG_BASE = 32'hC001_2000;
    localparam logic [ADDR_W:0]   DEF_HREG_SPAN = 33'h0_0000_1000;

    typedef struct packed {
        logic              valid;
        logic [NTGT-1:0]   sel;
        logic [ADDR_W-1:0] offset;
        logic              err;
        logic              fw;
        logic              write;
        logic [SIZE_W-1:0] size;
    } rsp_t;
endpackage

// File: rtl/lpc_win_match.sv
`timescale 1ns/1ps
// One address window: hit when BASE <= addr < BASE + SPAN, offset = addr - BASE
module lpc_win_match #(
    parameter int               AW   = 32,
    parameter logic [AW-1:0]    BASE = '0,
    parameter logic [AW:0]      SPAN = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] offset
);
    logic [AW:0] diff;

    always_comb begin
        diff   = {1'b0, addr} - {1'b0, BASE};
        hit    = !diff[AW] && (diff < SPAN);
        offset = diff[AW-1:0];
    end
endmodule

// File: rtl/lpc_win_prio.sv
`timescale 1ns/1ps
// Keeps only the lowest-index hit so overlapping windows resolve by index
module lpc_win_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] hit,
    output logic [N-1:0] grant
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    always_comb begin
        grant = hit & (~hit + ONE);
    end
endmodule

// File: rtl/lpc_opb_win_decode.sv
`timescale 1ns/1ps
module lpc_opb_win_decode
    import lpc_win_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FW_BASE   = DEF_FW_BASE,
    parameter logic [ADDR_W:0]   FW_SPAN   = DEF_FW_SPAN,
    parameter logic [ADDR_W-1:0] MEM_BASE  = DEF_MEM_BASE,
    parameter logic [ADDR_W:0]   MEM_SPAN  = DEF_MEM_SPAN,
    parameter logic [ADDR_W-1:0] IO_BASE   = DEF_IO_BASE,
    parameter logic [ADDR_W:0]   IO_SPAN   = DEF_IO_SPAN,
    parameter logic [ADDR_W-1:0] MREG_BASE = DEF_MREG_BASE,
    parameter logic [ADDR_W:0]   MREG_SPAN = DEF_MREG_SPAN,
    parameter logic [ADDR_W-1:0] HREG_BASE = DEF_HREG_BASE,
    parameter logic [ADDR_W:0]   HREG_SPAN = DEF_HREG_SPAN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [4:0]        rsp_sel,
    output logic [31:0]       rsp_offset,
    output logic              rsp_write,
    output logic [1:0]        rsp_size,
    output logic              rsp_decode_error,
    output logic              rsp_fw_cycle
);
    localparam logic [NTGT-1:0][ADDR_W-1:0] BASES =
        {HREG_BASE, MREG_BASE, IO_BASE, MEM_BASE, FW_BASE};
    localparam logic [NTGT-1:0][ADDR_W:0] SPANS =
        {HREG_SPAN, MREG_SPAN, IO_SPAN, MEM_SPAN, FW_SPAN};
    localparam logic [NTGT-1:0] REG_MASK =
        NTGT'((1 << T_MREG) | (1 << T_HREG));

    logic [NTGT-1:0]             hit;
    logic [NTGT-1:0]             win;
    logic [NTGT-1:0][ADDR_W-1:0] offs;

    generate
        for (genvar g = 0; g < NTGT; g++) begin : g_win
            lpc_win_match #(
                .AW   (ADDR_W),
                .BASE (BASES[g]),
                .SPAN (SPANS[g])
            ) u_match (
                .addr   (req_addr),
                .hit    (hit[g]),
                .offset (offs[g])
            );
        end
    endgenerate

    lpc_win_prio #(.N(NTGT)) u_prio (
        .hit   (hit),
        .grant (win)
    );

    rsp_t out_d, out_q;
    logic size_bad;

    always_comb begin
        out_d    = '0;
        size_bad = |(win & REG_MASK) && (req_size != SZ_WORD);
        if (req_valid) begin
            out_d.valid = 1'b1;
            out_d.write = req_write;
            out_d.size  = req_size;
            if (win == '0 || size_bad) begin
                out_d.err = 1'b1;
            end else begin
                out_d.sel = win;
                out_d.fw  = win[T_FW];
                for (int i = 0; i < NTGT; i++) begin
                    out_d.offset = out_d.offset | (offs[i] & {ADDR_W{win[i]}});
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid        = out_q.valid;
    assign rsp_sel          = out_q.sel;
    assign rsp_offset       = out_q.offset;
    assign rsp_write        = out_q.write;
    assign rsp_size         = out_q.size;
    assign rsp_decode_error = out_q.err;
    assign rsp_fw_cycle     = out_q.fw;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);                                           // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_sel == '0 && !rsp_decode_error && !rsp_fw_cycle)); // R2
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0(rsp_sel));                                   // R11
    AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_decode_error == (rsp_sel == '0)));               // R11
    AST_FW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fw_cycle == (rsp_sel[T_FW] && rsp_valid));                      // R5
    AST_REG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_sel[T_MREG] || rsp_sel[T_HREG]) |-> rsp_size == SZ_WORD);     // R8
    AST_IO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sel[T_IO] |-> ({1'b0, rsp_offset} < IO_SPAN));                  // R3
    AST_ERR_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_decode_error |-> (rsp_offset == '0 && !rsp_fw_cycle));         // R9
endmodule

// File: tb/sim_lpc_opb_win_decode.sv
`timescale 1ns/1ps
module sim_lpc_opb_win_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [4:0]  rsp_sel;
    logic [31:0] rsp_offset;
    logic        rsp_write;
    logic [1:0]  rsp_size;
    logic        rsp_decode_error;
    logic        rsp_fw_cycle;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lpc_opb_win_decode u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_sel(rsp_sel), .rsp_offset(rsp_offset),
        .rsp_write(rsp_write), .rsp_size(rsp_size),
        .rsp_decode_error(rsp_decode_error), .rsp_fw_cycle(rsp_fw_cycle)
    );

    // Bench model: returns {err, fw, sel[4:0], offset[31:0]}
    function automatic logic [38:0] model(input logic [31:0] a, input logic [1:0] sz);
        longint unsigned x = longint'(a);
        logic [4:0]  s = '0;
        logic [31:0] o = '0;
        if (x >= 64'hF000_0000)                              begin s = 5'b00001; o = a - 32'hF000_0000; end
        else if (x >= 64'hE001_0000 && x < 64'hF001_0000)    begin s = 5'b00010; o = a - 32'hE001_0000; end
        else if (x >= 64'hD001_0000 && x < 64'hD002_0000)    begin s = 5'b00100; o = a - 32'hD001_0000; end
        else if (x >= 64'hC001_0000 && x < 64'hC001_2000)    begin s = 5'b01000; o = a - 32'hC001_0000; end
        else if (x >= 64'hC001_2000 && x < 64'hC001_3000)    begin s = 5'b10000; o = a - 32'hC001_2000; end
        if ((s[3] || s[4]) && sz != 2'd2) begin s = '0; o = '0; end
        return {(s == '0), s[0], s, o};
    endfunction

    task automatic fail_line(input string req, input string what, input longint act, input longint exp);
        errors++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic cmp(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) fail_line(req, what, act, exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Drive one request, check the registered answer one clock later
    task automatic probe(input logic [31:0] a, input logic [1:0] sz, input logic wr, input string req);
        logic [38:0] e;
        e = model(a, sz);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
        @(posedge clk);
        @(negedge clk);
        cmp(req, "valid",  longint'(rsp_valid), 1);
        cmp(req, "sel",    longint'(rsp_sel), longint'(e[36:32]));
        cmp(req, "offset", longint'(rsp_offset), longint'(e[31:0]));
        cmp(req, "error",  longint'(rsp_decode_error), longint'(e[38]));
        cmp(req, "fw",     longint'(rsp_fw_cycle), longint'(e[37]));
        cmp("R2", "write", longint'(rsp_write), longint'(wr));
        cmp("R2", "size",  longint'(rsp_size), longint'(sz));
    endtask

    task automatic idle_check(input string req);
        req_valid = 1'b0; req_addr = 32'hF000_0000; req_size = 2'd2; req_write = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmp(req, "idle valid", longint'(rsp_valid), 0);
        cmp(req, "idle sel",   longint'(rsp_sel), 0);
        cmp(req, "idle err",   longint'(rsp_decode_error), 0);
        cmp(req, "idle fw",    longint'(rsp_fw_cycle), 0);
        cmp(req, "idle off",   longint'(rsp_offset), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_1234);
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R1", "reset valid", longint'(rsp_valid), 0);
        cmp("R1", "reset sel",   longint'(rsp_sel), 0);
        cmp("R1", "reset err",   longint'(rsp_decode_error), 0);
        rst_n = 1'b1;
        idle_check("R1");

        // R3 I/O window edges
        probe(32'hD001_0000, 2'd0, 1'b0, "R3");
        probe(32'hD001_FFFF, 2'd1, 1'b1, "R3");
        probe(32'hD002_0000, 2'd2, 1'b0, "R9");
        probe(32'hD000_FFFF, 2'd2, 1'b0, "R9");
        // R4 memory window
        probe(32'hE001_0000, 2'd3, 1'b1, "R4");
        probe(32'hEFFF_FFFF, 2'd0, 1'b0, "R4");
        probe(32'hE000_FFFF, 2'd2, 1'b0, "R9");
        // R5 / R6 firmware and overlap
        probe(32'hF000_0000, 2'd2, 1'b0, "R6");
        probe(32'hF000_FFFF, 2'd1, 1'b1, "R6");
        probe(32'hF001_0000, 2'd3, 1'b0, "R5");
        probe(32'hFFFF_FFFF, 2'd0, 1'b0, "R5");
        // R7 register windows, word size
        probe(32'hC001_0000, 2'd2, 1'b1, "R7");
        probe(32'hC001_1FFC, 2'd2, 1'b0, "R7");
        probe(32'hC001_2000, 2'd2, 1'b1, "R7");
        probe(32'hC001_2FFF, 2'd2, 1'b0, "R7");
        probe(32'hC001_3000, 2'd2, 1'b0, "R9");
        probe(32'hC000_FFFF, 2'd2, 1'b0, "R9");
        // R8 wrong size into register windows
        for (int s = 0; s < 4; s++) begin
            if (s != 2) begin
                probe(32'hC001_0010, 2'(s), 1'b0, "R8");
                probe(32'hC001_2010, 2'(s), 1'b1, "R8");
            end
        end
        // R10 every size into non-register windows
        for (int s = 0; s < 4; s++) begin
            probe(32'hD001_0100, 2'(s), 1'b0, "R10");
            probe(32'hE123_4567, 2'(s), 1'b1, "R10");
            probe(32'hF765_4321, 2'(s), 1'b0, "R10");
        end
        probe(32'h0000_0000, 2'd2, 1'b0, "R9");
        idle_check("R2");

        // R11 seeded random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a;
            logic [31:0] bases [5];
            logic [31:0] spans [5];
            int k;
            bases = '{32'hF000_0000, 32'hE001_0000, 32'hD001_0000, 32'hC001_0000, 32'hC001_2000};
            spans = '{32'h1000_0000, 32'h1000_0000, 32'h0001_0000, 32'h0000_2000, 32'h0000_1000};
            k = int'($urandom % 8);
            if (k < 5)       a = bases[k] + ($urandom % spans[k]);
            else if (k == 5) a = $urandom;
            else if (k == 6) a = bases[$urandom % 5] - 32'd1;
            else begin
                int j = int'($urandom % 5);
                a = bases[j] + spans[j] - 32'(($urandom % 2));
            end
            probe(a, ($urandom % 3 == 0) ? 2'($urandom) : 2'd2, 1'($urandom), "R11");
            if ($urandom % 16 == 0) idle_check("R2");
        end
        summary();
    end
endmodule